// File: doc/BRIEF.md
# VBUS Overvoltage and Over-Temperature Recovery Sequencer

This block supervises the power switches on a USB-C VBUS path. It watches three comparator levels from the analog side: a VBUS overvoltage trip, an over-temperature trip and a VBUS-present level from the undervoltage lockout comparator. It opens the provider and consumer gate enables as soon as a qualified fault is seen. It closes them again by itself after the fault has gone away. Overvoltage recovery waits a fixed window of clean cycles. Over-temperature recovery follows the comparator with no extra wait.

The comparator levels are asynchronous and pass through a synchronizer chain inside the block. The power mode and the two gate requests come from the register file in the same clock domain and are used directly. The block also drives an open-drain flag request and three live status bits for the register file. In the normal mode the flag reports faults. In every other mode it tells whether VBUS is present. The reset input is asynchronous on assertion and is assumed to be deasserted synchronously to `clk` upstream.

Top module: `ovp_recovery_seq`

## Requirements
- R1: Overvoltage detection and the consumer gate enable both need VBUS present. While the synchronized VBUS-present level is 0, `cons_gate_en` is 0, and an asserted overvoltage input neither sets `stat_ovp` nor drives the flag. `stat_vbus` follows the synchronized VBUS-present level.
- R2: In the cycle where the synchronized, VBUS-qualified overvoltage level first reads 1, `prov_gate_en` and `cons_gate_en` are both 0 and `stat_ovp` is 1.
- R3: After the qualified overvoltage level falls, `stat_ovp` and the gate lockout stay for exactly HOLD_CYC = CYC_PER_US*HOLD_US clean cycles. After that the gate enables follow their requests again.
- R4: If the qualified overvoltage level returns during the recovery window, the window is abandoned. A full new window of HOLD_CYC clean cycles starts when the level falls again.
- R5: While the synchronized over-temperature level is 1, both gate enables are 0 and `stat_otp` is 1. Both recover in the first cycle in which that level reads 0, with no added delay.
- R6: In normal mode (`pwr_mode` = 2'b11), `flag_pull` is 1 while the overvoltage lockout or the over-temperature level is active, and 0 only when neither is active.
- R7: In the off (2'b00), hibernate (2'b01) and low-power (2'b10) modes, `flag_pull` equals the synchronized VBUS-present level, whatever the faults are.
- R8: `prov_gate_en` can be 1 only in normal mode, with `prov_req` = 1 and no fault active. `cons_gate_en` is `cons_req` gated by VBUS present and no fault, in any mode.
- R9: Reset clears the synchronizers and the recovery state, so `stat_ovp`, `stat_otp`, `stat_vbus` and `flag_pull` are 0 during reset.
- R10: Each comparator input passes through SYNC_STAGES (default 2) flops. A change on a raw input reaches the outputs on the SYNC_STAGES-th rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ovp_cmp | input | 1 | Raw VBUS overvoltage comparator level |
| otp_cmp | input | 1 | Raw over-temperature comparator level |
| vbus_ok_cmp | input | 1 | Raw VBUS-above-lockout comparator level |
| pwr_mode | input | 2 | Power mode: 00 off, 01 hibernate, 10 low power, 11 normal |
| prov_req | input | 1 | Register request to close the provider switch |
| cons_req | input | 1 | Register request to close the consumer switch |
| prov_gate_en | output | 1 | Provider gate-driver enable |
| cons_gate_en | output | 1 | Consumer gate-driver enable |
| flag_pull | output | 1 | 1 requests the open-drain flag to pull low |
| stat_ovp | output | 1 | Overvoltage lockout active |
| stat_otp | output | 1 | Over-temperature active |
| stat_vbus | output | 1 | VBUS present |

## Verification
The bench builds the block with CYC_PER_US = 2 and HOLD_US = 4, so the recovery window is 8 cycles instead of thousands. With a window this short, a clean expiry, a recurrence in the middle of the window, an over-temperature event overlapping a pending window, and a loss of VBUS while a trip is active all fit in a short run. SYNC_STAGES stays at its default of 2, so the synchronizer latency is checked on the edge where the value should first appear.

// File: rtl/ovp_seq_pkg.sv
package ovp_seq_pkg;

  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_HIBER  = 2'b01,
    PM_LOWPWR = 2'b10,
    PM_NORMAL = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    RS_IDLE = 2'b00,
    RS_TRIP = 2'b01,
    RS_HOLD = 2'b10
  } rec_state_e;

  // index of each comparator lane in the synchronizer bank
  localparam int LANE_OVP  = 0;
  localparam int LANE_OTP  = 1;
  localparam int LANE_VBUS = 2;
  localparam int N_LANES   = 3;

endpackage

// File: rtl/ovp_sync_bank.sv
module ovp_sync_bank #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = async_in;
      end else begin : g_rest
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ovp_hold_timer.sv
module ovp_hold_timer
  import ovp_seq_pkg::*;
#(
  parameter int HOLD_CYC = 6400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_q,
  output logic lockout
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  rec_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if (trip_q) state_d = RS_TRIP;
      end
      RS_TRIP: begin
        if (!trip_q) begin
          cnt_en = 1'b1;
          cnt_d  = CNT_ONE;
          state_d = (HOLD_CYC <= 1) ? RS_IDLE : RS_HOLD;
        end
      end
      RS_HOLD: begin
        if (trip_q) begin
          state_d = RS_TRIP;
        end else if (cnt_q == CNT_LAST) begin
          state_d = RS_IDLE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + CNT_ONE;
        end
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // open the switch in the very cycle the qualified trip appears
  assign lockout = trip_q || (state_q != RS_IDLE);

endmodule

// File: rtl/ovp_out_mux.sv
module ovp_out_mux
  import ovp_seq_pkg::*;
(
  input  pwr_mode_e mode,
  input  logic      ovp_lock,
  input  logic      otp_s,
  input  logic      vbus_s,
  input  logic      prov_req,
  input  logic      cons_req,
  output logic      prov_gate_en,
  output logic      cons_gate_en,
  output logic      flag_pull
);

  logic any_fault;
  logic normal;

  always_comb begin
    any_fault    = ovp_lock || otp_s;
    normal       = (mode == PM_NORMAL);
    prov_gate_en = normal && prov_req && !any_fault;
    cons_gate_en = vbus_s && cons_req && !any_fault;
    flag_pull    = normal ? any_fault : vbus_s;
  end

endmodule

// File: rtl/ovp_recovery_seq.sv
module ovp_recovery_seq
  import ovp_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int HOLD_US     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovp_cmp,
  input  logic       otp_cmp,
  input  logic       vbus_ok_cmp,
  input  logic [1:0] pwr_mode,
  input  logic       prov_req,
  input  logic       cons_req,
  output logic       prov_gate_en,
  output logic       cons_gate_en,
  output logic       flag_pull,
  output logic       stat_ovp,
  output logic       stat_otp,
  output logic       stat_vbus
);

  localparam int HOLD_CYC = CYC_PER_US * HOLD_US;

  logic [N_LANES-1:0] raw_lanes;
  logic [N_LANES-1:0] sync_lanes;
  logic               ovp_s, otp_s, vbus_s;
  logic               ovp_qual;
  logic               ovp_lock;
  pwr_mode_e          mode;

  always_comb begin
    raw_lanes            = '0;
    raw_lanes[LANE_OVP]  = ovp_cmp;
    raw_lanes[LANE_OTP]  = otp_cmp;
    raw_lanes[LANE_VBUS] = vbus_ok_cmp;
  end

  ovp_sync_bank #(
    .WIDTH  (N_LANES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_lanes),
    .sync_out (sync_lanes)
  );

  assign ovp_s    = sync_lanes[LANE_OVP];
  assign otp_s    = sync_lanes[LANE_OTP];
  assign vbus_s   = sync_lanes[LANE_VBUS];
  // overvoltage detection is held off below the lockout level
  assign ovp_qual = ovp_s && vbus_s;
  assign mode     = pwr_mode_e'(pwr_mode);

  ovp_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_q  (ovp_qual),
    .lockout (ovp_lock)
  );

  ovp_out_mux u_mux (
    .mode         (mode),
    .ovp_lock     (ovp_lock),
    .otp_s        (otp_s),
    .vbus_s       (vbus_s),
    .prov_req     (prov_req),
    .cons_req     (cons_req),
    .prov_gate_en (prov_gate_en),
    .cons_gate_en (cons_gate_en),
    .flag_pull    (flag_pull)
  );

  assign stat_ovp  = ovp_lock;
  assign stat_otp  = otp_s;
  assign stat_vbus = vbus_s;

endmodule

// File: rtl/ovp_recovery_seq_chk.sv
module ovp_recovery_seq_chk #(
  parameter int HOLD_CYC = 6400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ovp_qual,
  input logic       otp_s,
  input logic       vbus_s,
  input logic [1:0] pwr_mode,
  input logic       prov_gate_en,
  input logic       cons_gate_en,
  input logic       flag_pull,
  input logic       stat_ovp
);

  int unsigned clean_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     clean_cnt <= 0;
    else if (!stat_ovp || ovp_qual) clean_cnt <= 0;
    else                            clean_cnt <= clean_cnt + 1;
  end

  a_r1_cons_needs_vbus: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_s |-> !cons_gate_en);

  a_r2_trip_opens_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_qual |-> (stat_ovp && !prov_gate_en && !cons_gate_en));

  a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_ovp) |-> (clean_cnt == HOLD_CYC));

  a_r5_otp_opens_gates: assert property (@(posedge clk) disable iff (!rst_n)
    otp_s |-> (!prov_gate_en && !cons_gate_en));

  a_r6_flag_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b11) |-> (flag_pull == (stat_ovp || otp_s)));

  a_r7_flag_is_vbus: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'b11) |-> (flag_pull == vbus_s));

  a_r8_prov_normal_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'b11) |-> !prov_gate_en);

  a_r1_trip_needs_vbus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ovp) |-> (ovp_qual && vbus_s));

endmodule

bind ovp_recovery_seq ovp_recovery_seq_chk #(
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ovp_qual     (ovp_qual),
  .otp_s        (otp_s),
  .vbus_s       (vbus_s),
  .pwr_mode     (pwr_mode),
  .prov_gate_en (prov_gate_en),
  .cons_gate_en (cons_gate_en),
  .flag_pull    (flag_pull),
  .stat_ovp     (stat_ovp)
);

// File: tb/ovp_recovery_seq_test.sv
`timescale 1ns/1ps
module ovp_recovery_seq_test;

  localparam int CPU  = 2;
  localparam int HUS  = 4;
  localparam int HOLD = CPU * HUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovp_cmp = 1'b0, otp_cmp = 1'b0, vbus_ok_cmp = 1'b0;
  logic [1:0] pwr_mode = 2'b11;
  logic       prov_req = 1'b0, cons_req = 1'b0;
  logic       prov_gate_en, cons_gate_en, flag_pull;
  logic       stat_ovp, stat_otp, stat_vbus;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ovp_recovery_seq #(.CYC_PER_US(CPU), .HOLD_US(HUS), .SYNC_STAGES(2)) uut (
    .clk, .rst_n, .ovp_cmp, .otp_cmp, .vbus_ok_cmp, .pwr_mode,
    .prov_req, .cons_req, .prov_gate_en, .cons_gate_en, .flag_pull,
    .stat_ovp, .stat_otp, .stat_vbus
  );

  // behavioural reference: two-deep delay queues and a clean-cycle tally
  bit o_q[$], t_q[$], v_q[$];
  bit m_lock;
  int m_clean;

  function automatic bit m_ovp();  return o_q[0]; endfunction
  function automatic bit m_otp();  return t_q[0]; endfunction
  function automatic bit m_vbus(); return v_q[0]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_q = '{0, 0}; t_q = '{0, 0}; v_q = '{0, 0};
      m_lock = 0; m_clean = 0;
    end else begin
      bit qual;
      qual = m_ovp() && m_vbus();
      if (qual) begin
        m_lock = 1; m_clean = 0;
      end else if (m_lock) begin
        m_clean++;
        if (m_clean == HOLD) begin m_lock = 0; m_clean = 0; end
      end
      void'(o_q.pop_front()); o_q.push_back(ovp_cmp);
      void'(t_q.pop_front()); t_q.push_back(otp_cmp);
      void'(v_q.pop_front()); v_q.push_back(vbus_ok_cmp);
    end
  end

  function automatic bit e_ovp();  return m_lock || (m_ovp() && m_vbus()); endfunction
  function automatic bit e_fault(); return e_ovp() || m_otp(); endfunction
  function automatic bit e_prov(); return (pwr_mode == 2'b11) && prov_req && !e_fault(); endfunction
  function automatic bit e_cons(); return m_vbus() && cons_req && !e_fault(); endfunction
  function automatic bit e_flag(); return (pwr_mode == 2'b11) ? e_fault() : m_vbus(); endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "cons_gate_en", cons_gate_en, e_cons());
      chk("R8", "prov_gate_en", prov_gate_en, e_prov());
      chk((pwr_mode == 2'b11) ? "R6" : "R7", "flag_pull", flag_pull, e_flag());
      chk("R3", "stat_ovp", stat_ovp, e_ovp());
      chk("R5", "stat_otp", stat_otp, m_otp());
      chk("R1", "stat_vbus", stat_vbus, m_vbus());
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // samples just before the next negedge comparison
  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    // R9: reset state
    cyc(3);
    chk("R9", "stat_ovp in reset", stat_ovp, 1'b0);
    chk("R9", "flag_pull in reset", flag_pull, 1'b0);
    chk("R9", "stat_vbus in reset", stat_vbus, 1'b0);
    chk("R9", "stat_otp in reset", stat_otp, 1'b0);
    rst_n = 1'b1;

    vbus_ok_cmp = 1; prov_req = 1; cons_req = 1;
    // R10: one edge later the synchronized level is not yet visible
    at_neg();
    chk("R10", "stat_vbus after one edge", stat_vbus, 1'b0);
    at_neg();
    chk("R10", "stat_vbus after two edges", stat_vbus, 1'b1);
    cyc(3);
    chk("R8", "provider closed in normal", prov_gate_en, 1'b1);

    // R2: trip opens both gates on the second edge
    ovp_cmp = 1;
    at_neg();
    chk("R10", "stat_ovp after one edge", stat_ovp, 1'b0);
    at_neg();
    chk("R2", "stat_ovp at trip", stat_ovp, 1'b1);
    chk("R2", "prov gate at trip", prov_gate_en, 1'b0);
    chk("R2", "cons gate at trip", cons_gate_en, 1'b0);
    cyc(2);
    ovp_cmp = 0;
    // R3: lockout lasts exactly HOLD clean cycles after the synced fall
    cyc(2 + HOLD - 1);
    chk("R3", "still locked on last clean cycle", stat_ovp, 1'b1);
    cyc(1);
    chk("R3", "released after window", stat_ovp, 1'b0);
    chk("R3", "gate back after window", cons_gate_en, 1'b1);
    cyc(2);

    // R4: recurrence mid-window restarts the count
    ovp_cmp = 1; cyc(2); ovp_cmp = 0; cyc(4);
    ovp_cmp = 1; cyc(1); ovp_cmp = 0;
    cyc(HOLD);
    chk("R4", "window restarted on recurrence", stat_ovp, 1'b1);
    cyc(6);
    chk("R4", "released after restarted window", stat_ovp, 1'b0);

    // R1: overvoltage ignored without VBUS
    vbus_ok_cmp = 0; cyc(3);
    ovp_cmp = 1; cyc(5);
    chk("R1", "no trip without vbus", stat_ovp, 1'b0);
    chk("R1", "no flag without vbus", flag_pull, 1'b0);
    ovp_cmp = 0; cyc(3);
    vbus_ok_cmp = 1; cyc(4);

    // R5: over-temperature with immediate recovery
    otp_cmp = 1; cyc(3);
    chk("R5", "otp opens consumer", cons_gate_en, 1'b0);
    otp_cmp = 0; cyc(2);
    chk("R5", "otp released without delay", cons_gate_en, 1'b1);
    cyc(2);

    // R6: overlap, flag released only when both clear
    ovp_cmp = 1; cyc(2); ovp_cmp = 0; cyc(2);
    otp_cmp = 1; cyc(HOLD + 2);
    chk("R6", "flag held by otp after ovp window", flag_pull, 1'b1);
    otp_cmp = 0; cyc(3);
    chk("R6", "flag released when no fault", flag_pull, 1'b0);

    // R7/R8: other modes
    pwr_mode = 2'b10; cyc(3);
    chk("R7", "low power flag shows vbus", flag_pull, 1'b1);
    chk("R8", "no provider in low power", prov_gate_en, 1'b0);
    vbus_ok_cmp = 0; cyc(3);
    chk("R7", "low power flag vbus gone", flag_pull, 1'b0);
    vbus_ok_cmp = 1; cyc(3);
    ovp_cmp = 1; cyc(3);
    chk("R7", "flag ignores fault in low power", flag_pull, 1'b1);
    ovp_cmp = 0; cyc(HOLD + 3);
    pwr_mode = 2'b01; cyc(3);
    pwr_mode = 2'b00; cyc(3);
    chk("R7", "off mode flag shows vbus", flag_pull, 1'b1);

    // VBUS lost during a trip ends the condition and starts the window
    pwr_mode = 2'b11; cyc(2);
    ovp_cmp = 1; cyc(4);
    vbus_ok_cmp = 0; cyc(HOLD + 4);
    chk("R1", "window expired after vbus loss", stat_ovp, 1'b0);
    ovp_cmp = 0; vbus_ok_cmp = 1; cyc(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule